// File: doc/BRIEF.md
# Maskable Interrupt Enable Controller

This block owns the enable flag for external maskable interrupts and decides, at each instruction retire boundary, whether a pending maskable request may be taken. Decoded flag-changing events arrive from the instruction pipeline as single-cycle strobes:

- explicit clear and explicit set
- a flags pop
- an interrupt return or a task switch, each carrying a restored flags image
- entry through an interrupt-type or trap-type gate
- a load of the stack segment

The controller compares the current privilege level with the I/O privilege level to decide which changes apply. For a clear or set that lacks privilege, it raises a one-cycle general-protection fault request.

A stack-segment load opens a short shadow. During the shadow, both maskable interrupts and debug exceptions are held off until the instruction after the load has retired. The shadow is exported as a blocking qualifier for the debug logic. Non-maskable interrupts and other exceptions never consult this block.

Top module: `intr_enable_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the enable flag reads 0, no fault is requested and no shadow is active.
- R2: An explicit set or clear applied when cpl <= iopl makes the enable flag 1 or 0 from the next cycle on.
- R3: An explicit set or clear applied when cpl > iopl leaves the flag unchanged and drives gpFault high for exactly the following cycle. No other event raises gpFault.
- R4: A flags pop with cpl <= iopl loads the flag from popIfValue. With cpl > iopl it leaves the flag unchanged and raises no fault.
- R5: An interrupt return or a task switch loads the flag from restoredIf, whatever the privilege levels are.
- R6: Gate entry with gateIsInterrupt = 1 clears the flag. Gate entry with gateIsInterrupt = 0 (trap type) leaves it unchanged.
- R7: A stack-segment load strobe starts a shadow. The shadow lasts from that cycle until two retire strobes have been seen, counting a retire in the strobe's own cycle as the loading instruction's own. While the shadow lasts, dbgBlock is 1 and intrAccept is 0.
- R8: A stack-segment load strobe seen while a shadow is already active is ignored. The shadow still ends at the retire that follows the first load's instruction.
- R9: intrAccept is 1 exactly in a cycle where retire = 1, intrPending = 1, the registered enable flag is 1 and no shadow is active. It responds in the same cycle.
- R10: When several flag events coincide, only one is applied. The order of precedence is gate entry, then interrupt return or task switch, then pop, then set, then clear. A lower-ranked clear or set that loses raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evClear | input | 1 | Explicit clear of the enable flag |
| evSet | input | 1 | Explicit set of the enable flag |
| evPopFlags | input | 1 | Flags pop event |
| popIfValue | input | 1 | Enable bit in the popped image |
| evIret | input | 1 | Interrupt return event |
| evTaskSwitch | input | 1 | Task switch event |
| restoredIf | input | 1 | Enable bit in the restored image |
| evGate | input | 1 | Handler entry through a gate |
| gateIsInterrupt | input | 1 | 1 = interrupt-type gate, 0 = trap-type gate |
| evSsLoad | input | 1 | Stack-segment load (move or pop) |
| retire | input | 1 | Instruction retire strobe |
| intrPending | input | 1 | External maskable request pending |
| cpl | input | PRIV_W | Current privilege level |
| iopl | input | PRIV_W | I/O privilege level |
| ifFlag | output | 1 | Enable flag |
| gpFault | output | 1 | General-protection fault request |
| intrAccept | output | 1 | Maskable interrupt may be taken now |
| dbgBlock | output | 1 | Shadow active: debug exceptions held off |

## Verification
The hardest situation to reach from the ports is a second stack-segment load that lands inside an open shadow, in particular in the same cycle as the retire that closes it. A directed sequence places the second strobe on that closing retire and then on a gap cycle with no retire. After each placement it holds intrPending and the flag high, so that the exact boundary where acceptance resumes is visible. A long random phase then mixes sparse events, random privilege pairs and frequent retires against the bench's reference model, which also reaches coincident events and precedence collisions.

// File: rtl/intr_enable_pkg.sv
package intr_enable_pkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic loadIf;      // write ifValue into the enable flag
    logic ifValue;     // value to write
    logic raiseGp;     // request a protection fault next cycle
    logic armShadow;   // open a new shadow
    logic armRetire;   // the arming cycle also retires the loader
    logic stepShadow;  // a retire consumed one shadow slot
  } ctlStrobes_t;

endpackage

// File: rtl/intr_enable_control.sv
module intr_enable_control
  import intr_enable_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              evClear,
  input  logic              evSet,
  input  logic              evPopFlags,
  input  logic              popIfValue,
  input  logic              evIret,
  input  logic              evTaskSwitch,
  input  logic              restoredIf,
  input  logic              evGate,
  input  logic              gateIsInterrupt,
  input  logic              evSsLoad,
  input  logic              retire,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] iopl,
  input  logic              shadowBusy,
  output ctlStrobes_t       strobes
);

  logic privOk;
  logic restoreEv;

  assign privOk    = (cpl <= iopl);
  assign restoreEv = evIret | evTaskSwitch;

  // Flag update: one winner per cycle, in fixed precedence.
  always_comb begin
    strobes = '0;
    if (evGate) begin
      if (gateIsInterrupt) begin
        strobes.loadIf  = 1'b1;
        strobes.ifValue = 1'b0;
      end
    end else if (restoreEv) begin
      strobes.loadIf  = 1'b1;
      strobes.ifValue = restoredIf;
    end else if (evPopFlags) begin
      if (privOk) begin
        strobes.loadIf  = 1'b1;
        strobes.ifValue = popIfValue;
      end
    end else if (evSet) begin
      if (privOk) begin
        strobes.loadIf  = 1'b1;
        strobes.ifValue = 1'b1;
      end else begin
        strobes.raiseGp = 1'b1;
      end
    end else if (evClear) begin
      if (privOk) begin
        strobes.loadIf  = 1'b1;
        strobes.ifValue = 1'b0;
      end else begin
        strobes.raiseGp = 1'b1;
      end
    end

    // Shadow sequencing: a load inside an open shadow is not re-armed.
    if (evSsLoad && !shadowBusy) begin
      strobes.armShadow = 1'b1;
      strobes.armRetire = retire;
    end else if (shadowBusy && retire) begin
      strobes.stepShadow = 1'b1;
    end
  end

endmodule

// File: rtl/intr_enable_datapath.sv
module intr_enable_datapath
  import intr_enable_pkg::*;
#(
  parameter int SHADOW_SPAN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStrobes_t strobes,
  input  logic        evSsLoad,
  input  logic        retire,
  input  logic        intrPending,
  output logic        shadowBusy,
  output logic        ifFlag,
  output logic        gpFault,
  output logic        intrAccept,
  output logic        dbgBlock
);

  localparam int SHADOW_W = $clog2(SHADOW_SPAN + 1);
  localparam logic [SHADOW_W-1:0] SPAN_VAL = SHADOW_W'(SHADOW_SPAN);

  logic [SHADOW_W-1:0] shadowLeft;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifFlag <= 1'b0;
    end else if (strobes.loadIf) begin
      ifFlag <= strobes.ifValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpFault <= 1'b0;
    end else begin
      gpFault <= strobes.raiseGp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadowLeft <= '0;
    end else if (strobes.armShadow) begin
      shadowLeft <= SPAN_VAL - SHADOW_W'(strobes.armRetire);
    end else if (strobes.stepShadow) begin
      shadowLeft <= shadowLeft - 1'b1;
    end
  end

  assign shadowBusy = (shadowLeft != '0);
  assign dbgBlock   = shadowBusy | evSsLoad;
  assign intrAccept = retire & intrPending & ifFlag & ~dbgBlock;

endmodule

// File: rtl/intr_enable_ctrl.sv
module intr_enable_ctrl
  import intr_enable_pkg::*;
#(
  parameter int PRIV_W      = 2,
  parameter int SHADOW_SPAN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evClear,
  input  logic              evSet,
  input  logic              evPopFlags,
  input  logic              popIfValue,
  input  logic              evIret,
  input  logic              evTaskSwitch,
  input  logic              restoredIf,
  input  logic              evGate,
  input  logic              gateIsInterrupt,
  input  logic              evSsLoad,
  input  logic              retire,
  input  logic              intrPending,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] iopl,
  output logic              ifFlag,
  output logic              gpFault,
  output logic              intrAccept,
  output logic              dbgBlock
);

  ctlStrobes_t strobes;
  logic        shadowBusy;

  intr_enable_control #(.PRIV_W(PRIV_W)) u_control (
    .evClear         (evClear),
    .evSet           (evSet),
    .evPopFlags      (evPopFlags),
    .popIfValue      (popIfValue),
    .evIret          (evIret),
    .evTaskSwitch    (evTaskSwitch),
    .restoredIf      (restoredIf),
    .evGate          (evGate),
    .gateIsInterrupt (gateIsInterrupt),
    .evSsLoad        (evSsLoad),
    .retire          (retire),
    .cpl             (cpl),
    .iopl            (iopl),
    .shadowBusy      (shadowBusy),
    .strobes         (strobes)
  );

  intr_enable_datapath #(.SHADOW_SPAN(SHADOW_SPAN)) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .evSsLoad    (evSsLoad),
    .retire      (retire),
    .intrPending (intrPending),
    .shadowBusy  (shadowBusy),
    .ifFlag      (ifFlag),
    .gpFault     (gpFault),
    .intrAccept  (intrAccept),
    .dbgBlock    (dbgBlock)
  );

endmodule

// File: rtl/intr_enable_chk.sv
module intr_enable_chk #(
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evClear,
  input logic              evSet,
  input logic              evPopFlags,
  input logic              popIfValue,
  input logic              evIret,
  input logic              evTaskSwitch,
  input logic              restoredIf,
  input logic              evGate,
  input logic              gateIsInterrupt,
  input logic              evSsLoad,
  input logic              retire,
  input logic              intrPending,
  input logic [PRIV_W-1:0] cpl,
  input logic [PRIV_W-1:0] iopl,
  input logic              ifFlag,
  input logic              gpFault,
  input logic              intrAccept,
  input logic              dbgBlock
);

  logic aboveSet;
  logic abovePop;
  assign aboveSet = evGate | evIret | evTaskSwitch | evPopFlags;
  assign abovePop = evGate | evIret | evTaskSwitch;

  AST_PRIV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evSet && !aboveSet && cpl <= iopl) |=> ifFlag);  // R2

  AST_PRIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evClear && !evSet && !aboveSet && cpl <= iopl) |=> !ifFlag);  // R2

  AST_UNPRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((evSet || evClear) && !aboveSet && cpl > iopl) |=> (gpFault && $stable(ifFlag)));  // R3

  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    gpFault |-> $past(evSet || evClear));  // R3

  AST_POP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (evPopFlags && !abovePop && cpl > iopl) |=> (!gpFault && $stable(ifFlag)));  // R4

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((evIret || evTaskSwitch) && !evGate) |=> (ifFlag == $past(restoredIf)));  // R5

  AST_INT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (evGate && gateIsInterrupt) |=> !ifFlag);  // R6

  AST_TRAP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (evGate && !gateIsInterrupt) |=> $stable(ifFlag));  // R6

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evSsLoad |-> (dbgBlock && !intrAccept));  // R7

  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    intrAccept |-> (retire && intrPending && ifFlag && !dbgBlock));  // R9

endmodule

bind intr_enable_ctrl intr_enable_chk #(.PRIV_W(PRIV_W)) u_chk (.*);

// File: tb/intr_enable_ctrl_tb.sv
module intr_enable_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic evClear, evSet, evPopFlags, popIfValue, evIret, evTaskSwitch, restoredIf;
  logic evGate, gateIsInterrupt, evSsLoad, retire, intrPending;
  logic [1:0] cpl, iopl;
  logic ifFlag, gpFault, intrAccept, dbgBlock;

  always #2 clk = ~clk;  // 250 MHz

  intr_enable_ctrl u_dut (.*);

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int mIf = 0;
  int mGp = 0;
  int mShadow = 0;

  task automatic check(string what, logic act, int expv);
    compared++;
    if (act !== expv[0]) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0b expected=%0d at %0t", phase, what, act, expv, $time);
    end
  endtask

  task automatic quiet();
    evClear = 0; evSet = 0; evPopFlags = 0; popIfValue = 0; evIret = 0;
    evTaskSwitch = 0; restoredIf = 0; evGate = 0; gateIsInterrupt = 0;
    evSsLoad = 0; retire = 0;
  endtask

  // Compare predictions before the edge, then advance the model at the edge.
  task automatic tick();
    int block;
    int priv;
    #1;
    block = (mShadow > 0 || evSsLoad) ? 1 : 0;
    check("ifFlag", ifFlag, mIf);
    check("gpFault", gpFault, mGp);
    check("dbgBlock", dbgBlock, block);
    check("intrAccept", intrAccept, (retire && intrPending && mIf == 1 && block == 0) ? 1 : 0);
    @(posedge clk);
    priv = (cpl <= iopl) ? 1 : 0;
    mGp = 0;
    if (evGate) begin
      if (gateIsInterrupt) mIf = 0;
    end else if (evIret || evTaskSwitch) mIf = restoredIf;
    else if (evPopFlags) begin
      if (priv == 1) mIf = popIfValue;
    end else if (evSet) begin
      if (priv == 1) mIf = 1; else mGp = 1;
    end else if (evClear) begin
      if (priv == 1) mIf = 0; else mGp = 1;
    end
    if (evSsLoad && mShadow == 0) mShadow = retire ? 1 : 2;
    else if (mShadow > 0 && retire) mShadow--;
    @(negedge clk);
    quiet();
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    quiet();
    intrPending = 0; cpl = 0; iopl = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1"; tick(); tick();

    // R2: privileged set then clear
    phase = "R2"; cpl = 1; iopl = 2;
    evSet = 1; tick(); tick();
    evClear = 1; tick(); tick();
    evSet = 1; tick();

    // R3: unprivileged clear and set, flag kept, one-cycle fault
    phase = "R3"; cpl = 3; iopl = 0;
    evClear = 1; tick(); tick(); tick();
    evSet = 1; tick(); tick();

    // R4: pop privileged loads, unprivileged is silent
    phase = "R4"; cpl = 0; iopl = 0;
    evPopFlags = 1; popIfValue = 0; tick(); tick();
    cpl = 2; iopl = 1;
    evPopFlags = 1; popIfValue = 1; tick(); tick();
    cpl = 0;
    evPopFlags = 1; popIfValue = 1; tick(); tick();

    // R5: restore ignores privilege
    phase = "R5"; cpl = 3; iopl = 0;
    evIret = 1; restoredIf = 0; tick(); tick();
    evTaskSwitch = 1; restoredIf = 1; tick(); tick();

    // R6: trap gate keeps, interrupt gate clears
    phase = "R6";
    evGate = 1; gateIsInterrupt = 0; tick(); tick();
    evGate = 1; gateIsInterrupt = 1; tick(); tick();
    evIret = 1; restoredIf = 1; tick();

    // R7: shadow spans loader's retire and the next retire
    phase = "R7"; intrPending = 1;
    retire = 1; tick();
    evSsLoad = 1; retire = 1; tick();
    tick();
    retire = 1; tick();
    retire = 1; tick();
    evSsLoad = 1; tick();
    retire = 1; tick();
    tick();
    retire = 1; tick();
    retire = 1; tick();

    // R8: second load inside the shadow, on the closing retire and on a gap
    phase = "R8";
    evSsLoad = 1; retire = 1; tick();
    evSsLoad = 1; retire = 1; tick();
    retire = 1; tick();
    evSsLoad = 1; retire = 1; tick();
    evSsLoad = 1; tick();
    retire = 1; tick();
    retire = 1; tick();

    // R9: each qualifier missing in turn
    phase = "R9";
    intrPending = 0; retire = 1; tick();
    intrPending = 1; tick();
    retire = 1; tick();
    evGate = 1; gateIsInterrupt = 1; tick();
    retire = 1; tick();

    // R10: coincident events
    phase = "R10"; cpl = 3; iopl = 0;
    evSet = 1; evIret = 1; restoredIf = 1; tick(); tick();
    evClear = 1; evPopFlags = 1; popIfValue = 0; tick(); tick();
    evGate = 1; gateIsInterrupt = 1; evTaskSwitch = 1; restoredIf = 1; evSet = 1; tick(); tick();
    cpl = 0;
    evSet = 1; evClear = 1; tick(); tick();

    // random mix against the model
    phase = "R9-mix";
    for (int i = 0; i < 4000; i++) begin
      evClear = ($urandom_range(0, 7) == 0);
      evSet = ($urandom_range(0, 7) == 0);
      evPopFlags = ($urandom_range(0, 9) == 0);
      popIfValue = $urandom_range(0, 1);
      evIret = ($urandom_range(0, 15) == 0);
      evTaskSwitch = ($urandom_range(0, 19) == 0);
      restoredIf = $urandom_range(0, 1);
      evGate = ($urandom_range(0, 15) == 0);
      gateIsInterrupt = $urandom_range(0, 1);
      evSsLoad = ($urandom_range(0, 5) == 0);
      retire = ($urandom_range(0, 2) != 0);
      intrPending = ($urandom_range(0, 3) != 0);
      cpl = 2'($urandom_range(0, 3));
      iopl = 2'($urandom_range(0, 3));
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule